// File: doc/BRIEF.md
# FG Period Speed Judge

This block judges motor speed from the frequency-generator (FG) pulse train. It counts strobes of a reference clock over each FG period and compares the result with a target count. The reference runs at the target multiple of the command clock, so a motor at the commanded speed yields exactly the target count per FG period. The target comes from two select bits through a fixed four-entry table that is not monotonic in its binary code. Each FG rising edge updates two active-low flags. One says the motor is too fast and feeds the speed loop. The other says the speed sits within one sixteenth of the target.

Alongside the period judge sits a phase comparator. It divides the command clock and the FG signal by two, then compares the rising edges of the two divided signals. It reports whether the command edge arrived first, and otherwise holds its last verdict. All inputs are single-bit levels already synchronous to `clk`. `ref_tick` is a one-cycle strobe per reference period.

Top module: `fg_speed_judge`

## Requirements
- R1: Target count from `cnt_sel` (bit 1 is the first select, bit 0 the second; 1 means high or open): 2'b11 gives 128, 2'b10 gives 512, 2'b01 gives 256, 2'b00 gives 1024 (default base 128).
- R2: On each FG rising edge `fast_n` is driven low if the measured count is below the target, and high otherwise.
- R3: On each FG rising edge `lock_n` is driven low if |count − target| ≤ target/16, and high otherwise.
- R4: The period count saturates at twice the target and never wraps, so a very slow motor reads as slow and unlocked.
- R5: `fast_n` and `lock_n` change only in the cycle after an FG rising edge is seen, and hold between edges.
- R6: The measured count is the number of `ref_tick` strobes from the cycle of the previous FG rise up to the cycle before the current one. This holds for any strobe rate.
- R7: `phase_out` goes high when a rising edge of the command clock divided by two comes before the next rising edge of the FG signal divided by two.
- R8: `phase_out` goes low when the divided FG edge comes first. It holds on every other cycle, and also when both divided edges coincide.
- R9: After synchronous reset, `fast_n`=1, `lock_n`=1, `phase_out`=0, and both dividers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| cmd_clk | input | 1 | Command clock level |
| fg_in | input | 1 | FG pulse level |
| cnt_sel | input | 2 | Target count select |
| fast_n | output | 1 | Low when over speed |
| lock_n | output | 1 | Low when within the speed window |
| phase_out | output | 1 | High when the divided command edge leads |

## Verification
The assertions assume that `fg_in` and `cmd_clk` are clean, synchronous levels, and that `cnt_sel` changes only between measurements. The bench drives every input on the falling clock edge and holds the select steady over each measured period. It keeps both edge inputs low through reset, so no edge appears at reset release. It spaces the FG rises far enough apart that the edge detector sees each one as a separate edge.

// File: rtl/spdj_pkg.sv
package spdj_pkg;
  // Non-monotonic select table: 11 -> base, 01 -> 2x, 10 -> 4x, 00 -> 8x
  function automatic int target_of(input logic [1:0] sel, input int base);
    case (sel)
      2'b11:   return base;
      2'b01:   return base * 2;
      2'b10:   return base * 4;
      default: return base * 8;
    endcase
  endfunction
endpackage

// File: rtl/spdj_edge.sv
module spdj_edge (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= d;
  end
  assign rise = d & ~prev;
endmodule

// File: rtl/spdj_period.sv
module spdj_period #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (restart)               cnt <= tick ? CW'(1) : '0;
    else if (tick && (cnt < limit)) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/spdj_window.sv
module spdj_window #(
  parameter int CW        = 12,
  parameter int WIN_SHIFT = 4
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] tgt,
  output logic          is_fast,
  output logic          in_win
);
  logic [CW-1:0] diff;
  always_comb begin
    is_fast = cnt < tgt;
    diff    = is_fast ? (tgt - cnt) : (cnt - tgt);
    in_win  = diff <= (tgt >> WIN_SHIFT);
  end
endmodule

// File: rtl/spdj_phase.sv
module spdj_phase (
  input  logic clk,
  input  logic rst,
  input  logic cmd_rise,
  input  logic fg_rise,
  output logic lead
);
  logic cdiv, fdiv, pend_c, pend_f;
  logic c_up, f_up;
  assign c_up = cmd_rise & ~cdiv;
  assign f_up = fg_rise & ~fdiv;

  always_ff @(posedge clk) begin
    if (rst) begin
      cdiv <= 1'b0; fdiv <= 1'b0;
      pend_c <= 1'b0; pend_f <= 1'b0;
      lead <= 1'b0;
    end else begin
      cdiv <= cdiv ^ cmd_rise;
      fdiv <= fdiv ^ fg_rise;
      if (c_up && f_up) begin
        pend_c <= 1'b0; pend_f <= 1'b0;
      end else if (c_up) begin
        if (pend_f) begin lead <= 1'b0; pend_f <= 1'b0; end
        else        pend_c <= 1'b1;
      end else if (f_up) begin
        if (pend_c) begin lead <= 1'b1; pend_c <= 1'b0; end
        else        pend_f <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fg_speed_judge.sv
module fg_speed_judge #(
  parameter int BASE_CNT  = 128,
  parameter int WIN_SHIFT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       cmd_clk,
  input  logic       fg_in,
  input  logic [1:0] cnt_sel,
  output logic       fast_n,
  output logic       lock_n,
  output logic       phase_out
);
  localparam int CW = $clog2(BASE_CNT * 16 + 1);

  logic [1:0]    raw, rise;
  logic          fg_rise, cmd_rise;
  logic [CW-1:0] tgt, lim, cnt;
  logic          is_fast, in_win;

  assign raw = {cmd_clk, fg_in};
  for (genvar i = 0; i < 2; i++) begin : g_edge
    spdj_edge u_edge (.clk(clk), .rst(rst), .d(raw[i]), .rise(rise[i]));
  end
  assign fg_rise  = rise[0];
  assign cmd_rise = rise[1];

  assign tgt = CW'(spdj_pkg::target_of(cnt_sel, BASE_CNT));
  assign lim = {tgt[CW-2:0], 1'b0};

  spdj_period #(.CW(CW)) u_per (
    .clk(clk), .rst(rst), .tick(ref_tick), .restart(fg_rise),
    .limit(lim), .cnt(cnt)
  );

  spdj_window #(.CW(CW), .WIN_SHIFT(WIN_SHIFT)) u_win (
    .cnt(cnt), .tgt(tgt), .is_fast(is_fast), .in_win(in_win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_n <= 1'b1;
      lock_n <= 1'b1;
    end else if (fg_rise) begin
      fast_n <= ~is_fast;
      lock_n <= ~in_win;
    end
  end

  spdj_phase u_ph (
    .clk(clk), .rst(rst), .cmd_rise(cmd_rise), .fg_rise(fg_rise),
    .lead(phase_out)
  );
endmodule

// File: rtl/spdj_chk.sv
module spdj_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          fg_rise,
  input logic          cmd_rise,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] tgt,
  input logic          fast_n,
  input logic          lock_n,
  input logic          phase_out
);
  always_comb begin
    if (!rst) a_r1_one_target: assert ($countones(tgt) == 1);
  end

  a_r2_fast_flag: assert property (@(posedge clk) disable iff (rst)
    (fg_rise && (cnt < tgt)) |=> !fast_n);

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
    ((cnt >= {tgt[CW-2:0], 1'b0}) && !fg_rise) |=> (cnt == $past(cnt)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !fg_rise |=> ($stable(fast_n) && $stable(lock_n)));

  a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !(fg_rise || cmd_rise) |=> $stable(phase_out));
endmodule

bind fg_speed_judge spdj_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .fg_rise(fg_rise), .cmd_rise(cmd_rise),
  .cnt(cnt), .tgt(tgt), .fast_n(fast_n), .lock_n(lock_n),
  .phase_out(phase_out)
);

// File: tb/tb_fg_speed_judge.sv
module tb_fg_speed_judge;
  logic clk = 1'b0, rst = 1'b1, ref_tick = 1'b1, cmd_clk = 1'b0, fg_in = 1'b0;
  logic [1:0] cnt_sel = 2'b11;
  logic fast_n, lock_n, phase_out;
  logic half_rate = 1'b0;
  int checks = 0, fails = 0;

  fg_speed_judge dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .cmd_clk(cmd_clk),
    .fg_in(fg_in), .cnt_sel(cnt_sel), .fast_n(fast_n), .lock_n(lock_n),
    .phase_out(phase_out)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (half_rate) ref_tick = ~ref_tick;
    else           ref_tick = 1'b1;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; fg_in = 1'b0; cmd_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // k periods of P cycles, then the final rise; sample one cycle later
  task automatic run_fg(input int p, input int k);
    for (int n = 0; n < k; n++) begin
      fg_in = 1'b1;
      repeat (p / 2) @(negedge clk);
      fg_in = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
    fg_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic judge(input string tag, input logic [1:0] sel, input int p,
                       input logic exp_fast_n, input logic exp_lock_n);
    cnt_sel = sel;
    run_fg(p, 2);
    chk({tag, " fast_n"}, fast_n, exp_fast_n);
    chk({tag, " lock_n"}, lock_n, exp_lock_n);
    fg_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_cmd();
    cmd_clk = 1'b1; repeat (2) @(negedge clk);
    cmd_clk = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic pulse_fg();
    fg_in = 1'b1; repeat (2) @(negedge clk);
    fg_in = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 fast_n", fast_n, 1'b1);
    chk("R9 lock_n", lock_n, 1'b1);
    chk("R9 phase_out", phase_out, 1'b0);
  endtask

  task automatic t_window_base();
    judge("R2 R3 on target 128", 2'b11, 128, 1'b1, 1'b0);
    judge("R2 R3 fast edge 120", 2'b11, 120, 1'b0, 1'b0);
    judge("R3 outside fast 119", 2'b11, 119, 1'b0, 1'b1);
    judge("R3 slow edge 136", 2'b11, 136, 1'b1, 1'b0);
    judge("R3 outside slow 137", 2'b11, 137, 1'b1, 1'b1);
  endtask

  task automatic t_select();
    judge("R1 sel=10 target 512", 2'b10, 512, 1'b1, 1'b0);
    judge("R1 sel=10 period 400", 2'b10, 400, 1'b0, 1'b1);
    judge("R1 sel=01 target 256 fast", 2'b01, 250, 1'b0, 1'b0);
    judge("R1 sel=00 target 1024", 2'b00, 1000, 1'b0, 1'b0);
    judge("R1 sel=00 period 900", 2'b00, 900, 1'b0, 1'b1);
  endtask

  task automatic t_saturate();
    judge("R4 long period", 2'b11, 600, 1'b1, 1'b1);
  endtask

  task automatic t_hold();
    judge("R5 set fast", 2'b11, 124, 1'b0, 1'b0);
    repeat (60) @(negedge clk);
    chk("R5 fast_n held", fast_n, 1'b0);
    chk("R5 lock_n held", lock_n, 1'b0);
  endtask

  task automatic t_half_rate();
    half_rate = 1'b1;
    @(negedge clk);
    judge("R6 half rate 256 cyc", 2'b11, 256, 1'b1, 1'b0);
    judge("R6 half rate 238 cyc", 2'b11, 238, 1'b0, 1'b1);
    half_rate = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_phase();
    do_reset();
    pulse_cmd();
    chk("R8 lone cmd edge holds", phase_out, 1'b0);
    pulse_fg();
    chk("R7 command leads", phase_out, 1'b1);
    pulse_cmd();
    pulse_fg();
    chk("R8 non-divided edges hold", phase_out, 1'b1);
    pulse_fg();
    pulse_cmd();
    chk("R8 command lags", phase_out, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_window_base();
    t_select();
    t_saturate();
    t_hold();
    t_half_rate();
    t_phase();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule